// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a small data cache that keeps the fast lookup of a direct-mapped array while giving every block a second place to live. A request first looks at its home line, chosen by the ordinary index bits of the word address. If that line does not hold the block, the controller inverts the least significant index bit and looks at the partner line. A hit in the partner line costs two more cycles than a hit in the home line. Only when both lines miss does the block go to the memory port.

When a block is found in its partner line, the two lines trade places, so the next access to that block hits on the fast path. A line fetched from memory always lands in the home line. The previous occupant of the home line moves to the partner line if that line is empty, and is dropped if it is not. Writes go straight through to memory. A write that misses in both lines does not allocate a line. Three event counters record how each request was served.

Top module: `pac_cache`

## Requirements
- R1: While reset is asserted and on the first cycle after it, req_ready is 1, rsp_valid, mem_rd and mem_wr are 0, all three counters read zero and every line is empty, so the first read of any address is a miss.
- R2: A request that hits its home line (index = low IDX_W address bits) is answered with rsp_valid on the cycle after acceptance; a read returns the stored word.
- R3: On a home-line miss the line whose index differs only in bit 0 is probed; a hit there is answered 3 cycles after acceptance.
- R4: A read that misses both lines raises mem_rd for exactly one cycle with mem_addr equal to the request address, starting 2 cycles after acceptance, and answers with mem_rdata on the cycle after mem_rvalid is sampled high.
- R5: After a hit in the partner line, the requested block and the home-line occupant are exchanged, so an immediate repeat of the same request hits the home line.
- R6: A line fetched on a read miss fills the home line; the displaced home occupant moves into the partner line only if that line is empty, otherwise it is dropped and a later access to it misses.
- R7: Each stored tag carries the address bit 0 of its block's home index, so a block in a partner line never hits for a different address sharing that line's index.
- R8: A write that hits either line updates the cached word and raises mem_wr for one cycle with the request address and data, in the cycle rsp_valid is high.
- R9: A write that misses both lines allocates nothing, writes memory and is answered 2 cycles after acceptance.
- R10: req_ready drops on the cycle after a request is accepted and stays low, also through the partner probe and the fill, until the response cycle has passed.
- R11: Each response increments exactly one of cnt_prim (home hit), cnt_alt (partner hit), cnt_miss (double miss), in the same cycle as rsp_valid; no counter moves at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| mem_rd | output | 1 | One-cycle line fetch request |
| mem_wr | output | 1 | One-cycle write-through request |
| mem_addr | output | ADDR_W | Memory address for fetch or write |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Fetched data valid |
| mem_rdata | input | DATA_W | Fetched data |
| cnt_prim | output | CNT_W | Home-line hit count |
| cnt_alt | output | CNT_W | Partner-line hit count |
| cnt_miss | output | CNT_W | Double-miss count |

## Verification
A wrong internal placement shows at the ports as a latency class that differs from the expected one: a lost swap turns the following repeat from a one-cycle answer into a three-cycle one, and a wrong fill or a missing tag marker turns a seven-cycle miss into a short hit with wrong data, visible on the very next request to that pair of lines. A broken write-through path stays hidden until the line is evicted and read back from memory, so the sequence forces that eviction a few requests later. Counter errors appear in the final totals and, per cycle, against the response strobe.

// File: rtl/pac_pkg.sv
package pac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIM,
        ST_ALT,
        ST_SWAP,
        ST_FILL
    } pac_state_e;

    localparam int unsigned N_EVT = 3;
    localparam int unsigned EVT_PRIM = 0;
    localparam int unsigned EVT_ALT  = 1;
    localparam int unsigned EVT_MISS = 2;
endpackage

// File: rtl/pac_line_array.sv
module pac_line_array #(
    parameter int unsigned IDX_W = 3,
    parameter int unsigned ENT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_p,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [ENT_W-1:0] rd_ent_p,
    output logic [ENT_W-1:0] rd_ent_a,
    input  logic             wr_en_p,
    input  logic [IDX_W-1:0] wr_idx_p,
    input  logic [ENT_W-1:0] wr_ent_p,
    input  logic             wr_en_a,
    input  logic [IDX_W-1:0] wr_idx_a,
    input  logic [ENT_W-1:0] wr_ent_a
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic [ENT_W-1:0] lines_q [LINES];

    assign rd_ent_p = lines_q[rd_idx_p];
    assign rd_ent_a = lines_q[rd_idx_a];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) lines_q[i] <= '0;
        end else begin
            if (wr_en_p) lines_q[wr_idx_p] <= wr_ent_p;
            if (wr_en_a) lines_q[wr_idx_a] <= wr_ent_a;
        end
    end
endmodule

// File: rtl/pac_tag_match.sv
module pac_tag_match #(
    parameter int unsigned KEY_W  = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic [KEY_W+DATA_W:0] ent,
    input  logic [KEY_W-1:0]      key,
    output logic                  hit,
    output logic [DATA_W-1:0]     data
);
    assign hit  = ent[KEY_W+DATA_W] && (ent[DATA_W +: KEY_W] == key);
    assign data = ent[DATA_W-1:0];
endmodule

// File: rtl/pac_event_counters.sv
module pac_event_counters #(
    parameter int unsigned N     = 3,
    parameter int unsigned CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              inc,
    output logic [N-1:0][CNT_W-1:0]   cnt
);
    for (genvar g = 0; g < N; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (inc[g]) cnt_q <= cnt_q + 1'b1;
        end
        assign cnt[g] = cnt_q;
    end
endmodule

// File: rtl/pac_cache.sv
module pac_cache
    import pac_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  cnt_prim,
    output logic [CNT_W-1:0]  cnt_alt,
    output logic [CNT_W-1:0]  cnt_miss
);
    localparam int unsigned UTAG_W = ADDR_W - IDX_W;
    localparam int unsigned KEY_W  = UTAG_W + 1;
    localparam int unsigned ENT_W  = 1 + KEY_W + DATA_W;

    typedef struct packed {
        pac_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
        logic              mem_rd;
        logic              mem_wr;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [IDX_W-1:0] idx_home, idx_part;
    logic [KEY_W-1:0] key;
    logic [ENT_W-1:0] rd_ent [2];
    logic             hit [2];
    logic [DATA_W-1:0] hit_data [2];
    logic             wen_p, wen_a;
    logic [ENT_W-1:0] went_p, went_a;
    logic [N_EVT-1:0] evt;
    logic [N_EVT-1:0][CNT_W-1:0] cnts;

    // home index from the address, partner index differs in bit 0;
    // the key keeps the home index bit 0 so partner residents stay distinct
    assign idx_home = regs_q.addr[IDX_W-1:0];
    assign idx_part = idx_home ^ IDX_W'(1);
    assign key      = {regs_q.addr[ADDR_W-1:IDX_W], regs_q.addr[0]};

    pac_line_array #(.IDX_W(IDX_W), .ENT_W(ENT_W)) i_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_p (idx_home),
        .rd_idx_a (idx_part),
        .rd_ent_p (rd_ent[0]),
        .rd_ent_a (rd_ent[1]),
        .wr_en_p  (wen_p),
        .wr_idx_p (idx_home),
        .wr_ent_p (went_p),
        .wr_en_a  (wen_a),
        .wr_idx_a (idx_part),
        .wr_ent_a (went_a)
    );

    for (genvar g = 0; g < 2; g++) begin : g_match
        pac_tag_match #(.KEY_W(KEY_W), .DATA_W(DATA_W)) i_match (
            .ent  (rd_ent[g]),
            .key  (key),
            .hit  (hit[g]),
            .data (hit_data[g])
        );
    end

    pac_event_counters #(.N(N_EVT), .CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (evt),
        .cnt   (cnts)
    );

    always_comb begin
        logic [ENT_W-1:0] moved;
        regs_d        = regs_q;
        regs_d.rsp_v  = 1'b0;
        regs_d.mem_rd = 1'b0;
        regs_d.mem_wr = 1'b0;
        wen_p  = 1'b0;
        wen_a  = 1'b0;
        went_p = rd_ent[0];
        went_a = rd_ent[0];
        evt    = '0;
        moved  = rd_ent[1];
        if (regs_q.wr) moved[DATA_W-1:0] = regs_q.wdata;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    regs_d.st    = ST_PRIM;
                    regs_d.wr    = req_write;
                    regs_d.addr  = req_addr;
                    regs_d.wdata = req_wdata;
                end
            end
            ST_PRIM: begin
                if (hit[0]) begin
                    evt[EVT_PRIM] = 1'b1;
                    regs_d.st     = ST_IDLE;
                    regs_d.rsp_v  = 1'b1;
                    regs_d.rsp_d  = regs_q.wr ? '0 : hit_data[0];
                    if (regs_q.wr) begin
                        wen_p         = 1'b1;
                        went_p        = {1'b1, key, regs_q.wdata};
                        regs_d.mem_wr = 1'b1;
                    end
                end else begin
                    regs_d.st = ST_ALT;
                end
            end
            ST_ALT: begin
                if (hit[1]) begin
                    regs_d.st = ST_SWAP;
                end else if (regs_q.wr) begin
                    evt[EVT_MISS] = 1'b1;
                    regs_d.st     = ST_IDLE;
                    regs_d.rsp_v  = 1'b1;
                    regs_d.rsp_d  = '0;
                    regs_d.mem_wr = 1'b1;
                end else begin
                    regs_d.st     = ST_FILL;
                    regs_d.mem_rd = 1'b1;
                end
            end
            ST_SWAP: begin
                evt[EVT_ALT] = 1'b1;
                wen_p        = 1'b1;
                went_p       = moved;
                wen_a        = 1'b1;
                went_a       = rd_ent[0];
                regs_d.st    = ST_IDLE;
                regs_d.rsp_v = 1'b1;
                regs_d.rsp_d = regs_q.wr ? '0 : hit_data[1];
                regs_d.mem_wr = regs_q.wr;
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    evt[EVT_MISS] = 1'b1;
                    wen_p         = 1'b1;
                    went_p        = {1'b1, key, mem_rdata};
                    wen_a         = !rd_ent[1][ENT_W-1];
                    went_a        = rd_ent[0];
                    regs_d.st     = ST_IDLE;
                    regs_d.rsp_v  = 1'b1;
                    regs_d.rsp_d  = mem_rdata;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q    <= '0;
            regs_q.st <= ST_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready = (regs_q.st == ST_IDLE);
    assign rsp_valid = regs_q.rsp_v;
    assign rsp_rdata = regs_q.rsp_d;
    assign mem_rd    = regs_q.mem_rd;
    assign mem_wr    = regs_q.mem_wr;
    assign mem_addr  = regs_q.addr;
    assign mem_wdata = regs_q.wdata;
    assign cnt_prim  = cnts[EVT_PRIM];
    assign cnt_alt   = cnts[EVT_ALT];
    assign cnt_miss  = cnts[EVT_MISS];
endmodule

// File: rtl/pac_cache_chk.sv
module pac_cache_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [CNT_W-1:0] cnt_prim,
    input logic [CNT_W-1:0] cnt_alt,
    input logic [CNT_W-1:0] cnt_miss
);
    logic [CNT_W+1:0] total;
    assign total = (CNT_W+2)'(cnt_prim) + (CNT_W+2)'(cnt_alt) + (CNT_W+2)'(cnt_miss);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R4
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !rsp_valid));

    // R4
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R8
    wr_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> rsp_valid);

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (total == $past(total) + 1'b1));

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $stable(total));
endmodule

bind pac_cache pac_cache_chk #(.CNT_W(CNT_W)) i_pac_cache_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .cnt_prim  (cnt_prim),
    .cnt_alt   (cnt_alt),
    .cnt_miss  (cnt_miss)
);

// File: tb/test_pac_cache.sv
module test_pac_cache;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned IDX_W   = 3;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CNT_W   = 16;
    localparam int          MEM_LAT = 4;
    localparam int          LAT_P   = 1;
    localparam int          LAT_A   = 3;
    localparam int          LAT_WM  = 2;
    localparam int          LAT_M   = 3 + MEM_LAT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_rd, mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_rvalid;
    logic [DATA_W-1:0] mem_rdata;
    logic [CNT_W-1:0]  cnt_prim, cnt_alt, cnt_miss;

    always #10 clk = ~clk;

    pac_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_pac_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cnt_prim(cnt_prim), .cnt_alt(cnt_alt), .cnt_miss(cnt_miss)
    );

    // backing memory with fixed latency
    logic [DATA_W-1:0] bmem [1 << ADDR_W];
    logic [ADDR_W-1:0] m_addr = '0;
    int                m_cnt = 0;
    int                n_mem_wr = 0;
    initial for (int i = 0; i < (1 << ADDR_W); i++) bmem[i] = 32'hC0DE_0000 + i * 13;
    always @(posedge clk) begin
        if (mem_wr) begin
            bmem[mem_addr] <= mem_wdata;
            n_mem_wr <= n_mem_wr + 1;
        end
        if (mem_rd) begin
            m_cnt  <= MEM_LAT;
            m_addr <= mem_addr;
        end else if (m_cnt != 0) begin
            m_cnt <= m_cnt - 1;
        end
    end
    assign mem_rvalid = (m_cnt == 1);
    assign mem_rdata  = bmem[m_addr];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    logic [DATA_W-1:0] refm [1 << ADDR_W];
    initial for (int i = 0; i < (1 << ADDR_W); i++) refm[i] = 32'hC0DE_0000 + i * 13;

    task automatic chk(input logic ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    typedef struct {
        logic        is_rd;
        logic [31:0] data;
        int          lat;
        int          acc;
        string       rq;
    } item_t;
    item_t sb [$];

    // monitor: compare each response against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2 unexpected response", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk((cyc - it.acc) == it.lat, {it.rq, " latency"}, cyc - it.acc, it.lat);
                    if (it.is_rd)
                        chk(rsp_rdata == it.data, {it.rq, " data"}, rsp_rdata, it.data);
                end
            end
        end
    end

    task automatic do_req(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input int lat, input string rq);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = a;
        req_wdata = wd;
        while (!req_ready) @(negedge clk);
        it.is_rd = !we;
        it.data  = refm[a];
        it.lat   = lat;
        it.acc   = cyc + 1;
        it.rq    = rq;
        sb.push_back(it);
        if (we) refm[a] = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready after accept", req_ready, 0);
        if (lat == LAT_A) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R10 ready during partner probe", req_ready, 0);
        end
        while (!req_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 state under reset
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(!mem_rd && !mem_wr, "R1 mem idle", {mem_rd, mem_wr}, 0);
        chk(cnt_prim == 0 && cnt_alt == 0 && cnt_miss == 0, "R1 counters",
            {cnt_prim, cnt_alt, cnt_miss}, 0);

        do_req(1'b0, 8'h10, '0, LAT_M, "R1 R4 first read misses");
        do_req(1'b0, 8'h10, '0, LAT_P, "R2 home hit");
        do_req(1'b0, 8'h20, '0, LAT_M, "R6 fill home, move to empty partner");
        do_req(1'b0, 8'h10, '0, LAT_A, "R3 partner hit");
        do_req(1'b0, 8'h10, '0, LAT_P, "R5 swap made home hit");
        do_req(1'b0, 8'h20, '0, LAT_A, "R3 R5 swapped-out block in partner");
        do_req(1'b0, 8'h11, '0, LAT_M, "R7 partner resident not matched");
        do_req(1'b0, 8'h10, '0, LAT_M, "R6 R7 displaced dropped");
        do_req(1'b1, 8'h11, 32'h1111_AAAA, LAT_P, "R8 write home hit");
        do_req(1'b0, 8'h11, '0, LAT_P, "R8 cached copy updated");
        do_req(1'b1, 8'h30, 32'h3030_5555, LAT_WM, "R9 write miss");
        do_req(1'b0, 8'h30, '0, LAT_M, "R9 no allocate");
        do_req(1'b0, 8'h21, '0, LAT_M, "R6 evict written block");
        do_req(1'b0, 8'h11, '0, LAT_M, "R8 memory holds written word");
        do_req(1'b0, 8'h02, '0, LAT_M, "R4 miss other pair");
        do_req(1'b0, 8'h12, '0, LAT_M, "R6 displaced to partner");
        do_req(1'b1, 8'h02, 32'h0202_7777, LAT_A, "R8 write partner hit");
        do_req(1'b0, 8'h02, '0, LAT_P, "R5 R8 swapped written line");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R11 all responses seen", sb.size(), 0);
        chk(cnt_prim == 5, "R11 home hit count", cnt_prim, 5);
        chk(cnt_alt == 3, "R11 partner hit count", cnt_alt, 3);
        chk(cnt_miss == 10, "R11 miss count", cnt_miss, 10);
        chk(n_mem_wr == 3, "R8 R9 memory writes", n_mem_wr, 3);
        chk(bmem[8'h30] == 32'h3030_5555, "R9 memory word", bmem[8'h30], 32'h3030_5555);
        finish_run();
    end
endmodule